// File: doc/BRIEF.md
# Integer Data-Processing ALU with Condition Flags

This block carries out one 32-bit data-processing step for a classic load/store integer core. The decode stage hands it a 4-bit operation code, a flag-update request, a first operand, a second operand that an external shifter has already shifted, and that shifter's carry-out. It also hands over the destination register index and the current condition flags. The block returns the result, a destination write strobe with the index passed through, and the next condition flags.

When the instruction carries an immediate, the block builds the second operand itself. It takes an 8-bit value and a 4-bit rotate field, and rotates the value right by twice the rotate field.

The block is purely combinational. The core registers its outputs at the writeback boundary. Conditional-execution gating, the register-specified shifter and exception return through the program counter belong to neighbouring logic.

Top module: `dpalu_top`

## Requirements
- R1: With `opCode` 0 (AND), 1 (XOR), 8 (test-AND), 9 (test-XOR), 12 (OR) and 14 (A AND NOT B), `result` is the corresponding bitwise function of the first operand and the effective second operand.
- R2: With `opCode` 2, `result` is A-B. With 4, `result` is A+B. With 5, `result` is A+B+C. With 6, `result` is A-B-(1-C). With 10 (compare), `result` is A-B. With 11 (compare-negative), `result` is A+B. Here C is `flagsIn[1]`.
- R3: With `opCode` 3, `result` is B-A. With 7, `result` is B-A-(1-C). The operand order is the reverse of codes 2 and 6.
- R4: Codes 8 to 11 never assert `wrEn`. All other codes assert `wrEn`. `wrIdx` always equals `dstIdx`.
- R5: Code 13 returns the effective second operand and code 15 returns its bitwise inverse. Both ignore `opA`.
- R6: When `useImm` is 1, the effective second operand is `immVal` zero-extended and rotated right by 2*`immRot`, and `opB` is ignored. `immOperand` always shows this rotated value.
- R7: For a logical code (0,1,8,9,12-15) with `setFlags`=1, the C flag becomes bit 31 of the rotated immediate when `useImm`=1 and `immRot`!=0. Otherwise it takes `shiftCarry`.
- R8: Flags are packed as `flagsIn`/`flagsOut` = {N,Z,C,V}. For a logical code with `setFlags`=1, N is `result[31]`, Z is 1 exactly when `result` is zero, and V is kept.
- R9: For an arithmetic code (2-7, 10, 11) with `setFlags`=1, N and Z follow `result`. C is the unsigned carry out, which for a subtraction means no borrow. V is two's-complement overflow.
- R10: With `setFlags`=0, `flagsOut` equals `flagsIn` for every code, and codes outside 8 to 11 still write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opCode | input | 4 | Operation code |
| setFlags | input | 1 | Request to update the condition flags |
| opA | input | 32 | First operand |
| opB | input | 32 | Pre-shifted second operand |
| shiftCarry | input | 1 | Carry-out of the external shifter |
| useImm | input | 1 | Select the rotated immediate as second operand |
| immVal | input | 8 | Immediate value |
| immRot | input | 4 | Immediate rotate field (rotate by twice this) |
| dstIdx | input | 4 | Destination register index |
| flagsIn | input | 4 | Current flags {N,Z,C,V} |
| result | output | 32 | Operation result |
| wrEn | output | 1 | Destination write strobe |
| wrIdx | output | 4 | Destination index for the write |
| flagsOut | output | 4 | Next flags {N,Z,C,V} |
| immOperand | output | 32 | Rotated immediate |

## Verification
The main sweep covers all sixteen codes, both flag-update settings, both incoming carry values and both shifter carries. It runs over eight operand pairs: zero pairs, an all-ones minuend, signed-limit pairs, equal operands and mixed bit patterns. Together these separate carry-in use from a constant carry, reversed from forward subtraction, unsigned carry from signed overflow, and shifter carry from the adder carry.

A second sweep runs the immediate path through every rotate amount with a set of byte values. It drives a distracting `opB`, so that a leaked register operand and a wrong rotate carry are both visible. A zero rotate confirms that the shifter carry is used in that case.

// File: rtl/dpalu_pkg.sv
package dpalu_pkg;
  typedef enum logic [1:0] {
    CIN_ZERO = 2'd0,
    CIN_ONE  = 2'd1,
    CIN_FLAG = 2'd2
  } cinSel_e;

  typedef enum logic [2:0] {
    LF_AND  = 3'd0,
    LF_XOR  = 3'd1,
    LF_OR   = 3'd2,
    LF_PASS = 3'd3,
    LF_ANDN = 3'd4,
    LF_NOT  = 3'd5
  } logicFn_e;

  typedef struct packed {
    logic     arith;
    logic     swapOps;
    logic     invSecond;
    cinSel_e  cinSel;
    logicFn_e logicFn;
    logic     writeDst;
  } aluCtrl_t;

  localparam int FLAG_N = 3;
  localparam int FLAG_Z = 2;
  localparam int FLAG_C = 1;
  localparam int FLAG_V = 0;
endpackage

// File: rtl/dpalu_ctrl.sv
module dpalu_ctrl
  import dpalu_pkg::*;
#(
  parameter int OP_W = 4
) (
  input  logic [OP_W-1:0] opCode,
  output aluCtrl_t        ctl
);
  always_comb begin
    ctl = '{arith: 1'b0, swapOps: 1'b0, invSecond: 1'b0,
            cinSel: CIN_ZERO, logicFn: LF_AND, writeDst: 1'b1};
    unique case (opCode)
      4'h0, 4'h8: ctl.logicFn = LF_AND;
      4'h1, 4'h9: ctl.logicFn = LF_XOR;
      4'hC:       ctl.logicFn = LF_OR;
      4'hD:       ctl.logicFn = LF_PASS;
      4'hE:       ctl.logicFn = LF_ANDN;
      4'hF:       ctl.logicFn = LF_NOT;
      4'h2, 4'hA: begin ctl.arith = 1'b1; ctl.invSecond = 1'b1; ctl.cinSel = CIN_ONE; end
      4'h3: begin ctl.arith = 1'b1; ctl.swapOps = 1'b1; ctl.invSecond = 1'b1; ctl.cinSel = CIN_ONE; end
      4'h4, 4'hB: ctl.arith = 1'b1;
      4'h5: begin ctl.arith = 1'b1; ctl.cinSel = CIN_FLAG; end
      4'h6: begin ctl.arith = 1'b1; ctl.invSecond = 1'b1; ctl.cinSel = CIN_FLAG; end
      4'h7: begin ctl.arith = 1'b1; ctl.swapOps = 1'b1; ctl.invSecond = 1'b1; ctl.cinSel = CIN_FLAG; end
      default: ctl.logicFn = LF_AND;
    endcase
    if (opCode[3:2] == 2'b10) ctl.writeDst = 1'b0;
  end

  always_comb begin
    if (!$isunknown(opCode)) begin
      assert_cmp_nowrite_R4: assert (!(opCode >= 4'h8 && opCode <= 4'hB) || !ctl.writeDst)
        else $error("compare code requested a write");
      assert_logic_noarith_R1: assert (!(opCode inside {4'h0, 4'h1, 4'h8, 4'h9, 4'hC, 4'hD, 4'hE, 4'hF}) || !ctl.arith)
        else $error("logical code routed to adder");
    end
  end
endmodule

// File: rtl/dpalu_immgen.sv
module dpalu_immgen #(
  parameter int DATA_W   = 32,
  parameter int IMM_W    = 8,
  parameter int ROT_W    = 4,
  parameter int ROT_STEP = 2
) (
  input  logic [IMM_W-1:0]  immVal,
  input  logic [ROT_W-1:0]  immRot,
  output logic [DATA_W-1:0] immOut
);
  localparam int SH_W = $clog2(DATA_W) + 1;

  logic [DATA_W-1:0] extVal;
  logic [SH_W-1:0]   rotAmt;

  always_comb begin
    extVal = {{(DATA_W-IMM_W){1'b0}}, immVal};
    rotAmt = SH_W'(immRot) * SH_W'(ROT_STEP);
    immOut = (extVal >> rotAmt) | (extVal << (SH_W'(DATA_W) - rotAmt));
  end

  always_comb begin
    if (!$isunknown({immVal, immRot})) begin
      assert_imm_bits_kept_R6: assert ($countones(immOut) == $countones(immVal))
        else $error("rotation lost or gained bits");
      assert_imm_norot_R6: assert (immRot != '0 || immOut == extVal)
        else $error("zero rotate altered value");
    end
  end
endmodule

// File: rtl/dpalu_datapath.sv
module dpalu_datapath
  import dpalu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  aluCtrl_t          ctl,
  input  logic              setFlags,
  input  logic [DATA_W-1:0] srcA,
  input  logic [DATA_W-1:0] srcB,
  input  logic              logicCarry,
  input  logic [3:0]        flagsIn,
  output logic [DATA_W-1:0] result,
  output logic [3:0]        flagsOut
);
  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] addX, addY, logicRes, sumRes;
  logic [DATA_W:0]   sumWide;
  logic              carryIn, addOvf;

  always_comb begin
    addX = ctl.swapOps ? srcB : srcA;
    addY = ctl.swapOps ? srcA : srcB;
    if (ctl.invSecond) addY = ~addY;
    unique case (ctl.cinSel)
      CIN_ONE:  carryIn = 1'b1;
      CIN_FLAG: carryIn = flagsIn[FLAG_C];
      default:  carryIn = 1'b0;
    endcase
    sumWide = {1'b0, addX} + {1'b0, addY} + {{DATA_W{1'b0}}, carryIn};
    sumRes  = sumWide[MSB:0];
    addOvf  = (addX[MSB] == addY[MSB]) && (sumRes[MSB] != addX[MSB]);
  end

  always_comb begin
    unique case (ctl.logicFn)
      LF_XOR:  logicRes = srcA ^ srcB;
      LF_OR:   logicRes = srcA | srcB;
      LF_PASS: logicRes = srcB;
      LF_ANDN: logicRes = srcA & ~srcB;
      LF_NOT:  logicRes = ~srcB;
      default: logicRes = srcA & srcB;
    endcase
  end

  always_comb begin
    result   = ctl.arith ? sumRes : logicRes;
    flagsOut = flagsIn;
    if (setFlags) begin
      flagsOut[FLAG_N] = result[MSB];
      flagsOut[FLAG_Z] = (result == '0);
      flagsOut[FLAG_C] = ctl.arith ? sumWide[DATA_W] : logicCarry;
      if (ctl.arith) flagsOut[FLAG_V] = addOvf;
    end
  end

  always_comb begin
    if (!$isunknown({ctl, setFlags, srcA, srcB, flagsIn, logicCarry})) begin
      assert_flags_hold_R10: assert (setFlags || flagsOut == flagsIn)
        else $error("flags moved without request");
      assert_logic_keeps_v_R8: assert (!setFlags || ctl.arith || flagsOut[FLAG_V] == flagsIn[FLAG_V])
        else $error("logical op changed V");
      assert_zero_flag_R9: assert (!setFlags || flagsOut[FLAG_Z] == (result == '0))
        else $error("Z disagrees with result");
      assert_sign_flag_R8: assert (!setFlags || flagsOut[FLAG_N] == result[MSB])
        else $error("N disagrees with result");
    end
  end
endmodule

// File: rtl/dpalu_top.sv
module dpalu_top
  import dpalu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 8,
  parameter int ROT_W  = 4,
  parameter int OP_W   = 4,
  parameter int IDX_W  = 4
) (
  input  logic [OP_W-1:0]   opCode,
  input  logic              setFlags,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic              shiftCarry,
  input  logic              useImm,
  input  logic [IMM_W-1:0]  immVal,
  input  logic [ROT_W-1:0]  immRot,
  input  logic [IDX_W-1:0]  dstIdx,
  input  logic [3:0]        flagsIn,
  output logic [DATA_W-1:0] result,
  output logic              wrEn,
  output logic [IDX_W-1:0]  wrIdx,
  output logic [3:0]        flagsOut,
  output logic [DATA_W-1:0] immOperand
);
  aluCtrl_t          ctl;
  logic [DATA_W-1:0] srcB;
  logic              logicCarry;

  dpalu_ctrl #(.OP_W(OP_W)) u_ctrl (.opCode(opCode), .ctl(ctl));

  dpalu_immgen #(.DATA_W(DATA_W), .IMM_W(IMM_W), .ROT_W(ROT_W), .ROT_STEP(2)) u_imm (
    .immVal(immVal), .immRot(immRot), .immOut(immOperand));

  always_comb begin
    srcB       = useImm ? immOperand : opB;
    logicCarry = (useImm && immRot != '0) ? immOperand[DATA_W-1] : shiftCarry;
  end

  dpalu_datapath #(.DATA_W(DATA_W)) u_dp (
    .ctl(ctl), .setFlags(setFlags), .srcA(opA), .srcB(srcB),
    .logicCarry(logicCarry), .flagsIn(flagsIn),
    .result(result), .flagsOut(flagsOut));

  assign wrEn  = ctl.writeDst;
  assign wrIdx = dstIdx;

  always_comb begin
    if (!$isunknown({opCode, setFlags, useImm, immVal, immRot, shiftCarry})) begin
      assert_imm_carry_R7: assert (!(setFlags && useImm && immRot != '0 &&
          opCode inside {4'h0, 4'h1, 4'h8, 4'h9, 4'hC, 4'hD, 4'hE, 4'hF}) ||
          flagsOut[FLAG_C] == immOperand[DATA_W-1])
        else $error("logical C not from rotated immediate");
      assert_mov_imm_R5: assert (!(useImm && opCode == 4'hD) || result == immOperand)
        else $error("move of immediate wrong");
    end
  end
endmodule

// File: tb/dpalu_top_tb.sv
module dpalu_top_tb;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic [3:0]  opCode, immRot, dstIdx, flagsIn, wrIdx, flagsOut;
  logic        setFlags, shiftCarry, useImm, wrEn;
  logic [31:0] opA, opB, result, immOperand;
  logic [7:0]  immVal;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  dpalu_top u_dut (
    .opCode(opCode), .setFlags(setFlags), .opA(opA), .opB(opB),
    .shiftCarry(shiftCarry), .useImm(useImm), .immVal(immVal), .immRot(immRot),
    .dstIdx(dstIdx), .flagsIn(flagsIn), .result(result), .wrEn(wrEn),
    .wrIdx(wrIdx), .flagsOut(flagsOut), .immOperand(immOperand));

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s op=%h sf=%0d: actual %h expected %h", req, what, opCode, setFlags, act, exp);
    end
  endtask

  function automatic bit ovf(input longint v);
    return (v > 64'sd2147483647) || (v < -64'sd2147483648);
  endfunction

  // Reference computed from the requirements with wide integer arithmetic.
  task automatic model(input logic [3:0] op, input logic sf, input logic [31:0] a, input logic [31:0] b,
                       input logic [3:0] fl, input logic lc,
                       output logic [31:0] r, output logic we, output logic [3:0] nf);
    longint ua, ub, sa, sb, w, s;
    longint brw;
    bit isArith, isSub, rev;
    logic c, v;
    ua = longint'(a); ub = longint'(b);
    sa = longint'($signed(a)); sb = longint'($signed(b));
    isArith = 1; isSub = 0; rev = 0; brw = 0; c = 0; v = 0; r = '0;
    case (op)
      4'h2, 4'hA: isSub = 1;
      4'h3: begin isSub = 1; rev = 1; end
      4'h4, 4'hB: ;
      4'h5: ;
      4'h6: begin isSub = 1; brw = fl[1] ? 0 : 1; end
      4'h7: begin isSub = 1; rev = 1; brw = fl[1] ? 0 : 1; end
      default: isArith = 0;
    endcase
    if (isArith) begin
      if (isSub) begin
        if (rev) begin w = ub - ua - brw; s = sb - sa - brw; c = (ub >= ua + brw); end
        else     begin w = ua - ub - brw; s = sa - sb - brw; c = (ua >= ub + brw); end
      end else begin
        w = ua + ub + ((op == 4'h5 && fl[1]) ? 1 : 0);
        s = sa + sb + ((op == 4'h5 && fl[1]) ? 1 : 0);
        c = w[32];
      end
      r = w[31:0];
      v = ovf(s);
    end else begin
      case (op)
        4'h0, 4'h8: r = a & b;
        4'h1, 4'h9: r = a ^ b;
        4'hC: r = a | b;
        4'hD: r = b;
        4'hE: r = a & ~b;
        default: r = ~b;
      endcase
      c = lc; v = fl[0];
    end
    we = !(op >= 4'h8 && op <= 4'hB);
    nf = sf ? {r[31], (r == 0), c, v} : fl;
  endtask

  function automatic logic [31:0] rotImm(input logic [7:0] val, input logic [3:0] rot);
    logic [31:0] t;
    t = {24'd0, val};
    for (int k = 0; k < 2 * rot; k++) t = {t[0], t[31:1]};
    return t;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog R1: actual timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] aTab [8];
    logic [31:0] bTab [8];
    logic [7:0]  vTab [8];
    logic [31:0] er, ei;
    logic        ew;
    logic [3:0]  ef;
    string       rq, fq;
    aTab = '{32'h0, 32'hFFFFFFFF, 32'h7FFFFFFF, 32'h80000000, 32'h12345678, 32'h5, 32'h80000000, 32'hA5A5A5A5};
    bTab = '{32'h0, 32'h1, 32'h1, 32'h80000000, 32'h12345678, 32'h9, 32'h1, 32'h0F0F0F0F};
    vTab = '{8'h01, 8'h80, 8'hFF, 8'h3C, 8'hA5, 8'h00, 8'h7F, 8'hC3};

    opCode = 4'h0; setFlags = 0; opA = 0; opB = 0; shiftCarry = 0; useImm = 0;
    immVal = 0; immRot = 0; dstIdx = 4'h3; flagsIn = 4'h0;
    @(negedge clk);
    // Reset-state style check: all-zero inputs give zero AND result, flags kept.
    check("R1", "idle result", result, 32'h0);
    check("R10", "idle flags", {28'd0, flagsOut}, 32'h0);

    for (int op = 0; op < 16; op++)
      for (int sf = 0; sf < 2; sf++)
        for (int cf = 0; cf < 2; cf++)
          for (int sc = 0; sc < 2; sc++)
            for (int p = 0; p < 8; p++) begin
              @(posedge clk);
              opCode = op[3:0]; setFlags = sf[0]; opA = aTab[p]; opB = bTab[p];
              shiftCarry = sc[0]; useImm = 0; dstIdx = 4'(op + p);
              flagsIn = {p[0], p[1], cf[0], p[2]};
              model(op[3:0], sf[0], aTab[p], bTab[p], flagsIn, sc[0], er, ew, ef);
              @(negedge clk);
              if (op == 3 || op == 7) rq = "R3";
              else if (op == 13 || op == 15) rq = "R5";
              else if ((op >= 2 && op <= 7) || op == 10 || op == 11) rq = "R2";
              else rq = "R1";
              if (!sf[0]) fq = "R10";
              else if ((op >= 2 && op <= 7) || op == 10 || op == 11) fq = "R9";
              else fq = "R7 R8";
              check(rq, "result", result, er);
              check("R4", "write enable", {31'd0, wrEn}, {31'd0, ew});
              check("R4", "write index", {28'd0, wrIdx}, {28'd0, dstIdx});
              check(fq, "flags", {28'd0, flagsOut}, {28'd0, ef});
            end

    // Immediate path: move and add with every rotate amount.
    for (int rt = 0; rt < 16; rt++)
      for (int vi = 0; vi < 8; vi++)
        for (int sc = 0; sc < 2; sc++) begin
          @(posedge clk);
          opCode = 4'hD; setFlags = 1; opA = 32'h13579BDF; opB = 32'hDEADBEEF;
          useImm = 1; immVal = vTab[vi]; immRot = rt[3:0]; shiftCarry = sc[0];
          flagsIn = 4'b0101;
          ei = rotImm(vTab[vi], rt[3:0]);
          @(negedge clk);
          check("R6", "imm operand", immOperand, ei);
          check("R6", "mov imm result", result, ei);
          check("R7", "imm carry", {31'd0, flagsOut[1]}, {31'd0, (rt != 0) ? ei[31] : sc[0]});
          check("R8", "imm keep V", {31'd0, flagsOut[0]}, 32'd1);
          @(posedge clk);
          opCode = 4'h4;
          @(negedge clk);
          check("R6", "add imm result", result, 32'h13579BDF + ei);
        end

    done = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule